// File: doc/BRIEF.md
# Low-Power Lane Direction Handover

This block controls the direction of one bidirectional data lane of a low-power serial link. Exactly one end of the lane drives it at any time. The end that drives it (the owner) can be asked to give the lane away. It then plays out a fixed sequence of line states, parks the lane in the all-low bridge state and stops driving. The other end (the listener) watches the sampled line and recognises that sequence. It then waits a short settling interval, drives the bridge state itself, and finishes by returning the lane to the stop state with itself as the new owner.

Every phase length is a whole multiple of one low-power period. That period is given in clock cycles on `lpx_cycles`. The phases are deliberately unequal. The side that gives the lane away holds the bridge for four periods. The side that takes it holds the bridge for five periods, after a settle wait of one period. If a line state arrives that does not fit the expected order, the exchange stops and the block returns to the stop state with its starting direction. The block has no data path, so all of its pins are plain control and status levels with no handshake.

Top module: `lp_lane_turnaround`

## Requirements
- R1: While reset is held, and after it is released with default parameters, the block owns the lane. It drives LP-11 (`line_out` = 2'b11; the bit order is {P,N}, so LP-10 is 2'b10) with `line_oe` and `own_lane` high.
- R2: When the owner is idle in LP-11 and `ta_req` is high at a clock edge, `line_out` becomes LP-10 after that edge. It then shows LP-10, LP-00 and LP-10, each for one low-power period of cycles.
- R3: After that, the owner drives LP-00 for four periods. It then drops `line_oe` and `own_lane` together. Whenever `line_oe` is low, `line_out` reads LP-11.
- R4: A released side that then sees LP-00, then LP-10, then LP-11 settles as a listener, with `line_oe` and `own_lane` low.
- R5: While a released side waits for the far end, it accepts only LP-00 or LP-10 in the first wait step and only LP-10 or LP-11 in the second. Any other line state makes it take the lane back in LP-11 right after that edge.
- R6: If a released side stays in either wait step for eight periods, it takes the lane back in LP-11.
- R7: A listener recognises a request only as LP-10, LP-00, LP-10, LP-00, where each state may last any number of cycles. Any state out of that order, including LP-01, sends it back to listening without driving.
- R8: After the final LP-00 of a request, the listener waits one period. During that wait it keeps `line_oe` low, and any line state other than LP-00 sends it back to listening.
- R9: The taking side then raises `line_oe` and drives LP-00 for five periods while `own_lane` stays low.
- R10: The taking side then drives LP-10 for one period, then LP-11 with `own_lane` high.
- R11: `ta_req` has no effect on a block that does not own the lane.
- R12: An `lpx_cycles` value of zero acts as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lpx_cycles | input | CNT_W | Low-power period length in clock cycles |
| ta_req | input | 1 | Request to hand the lane to the far end |
| line_in | input | 2 | Sampled line state {P,N} |
| line_out | output | 2 | Driven line state {P,N} |
| line_oe | output | 1 | High while this end drives the lane |
| own_lane | output | 1 | High while this end owns the lane |

## Verification
A full round trip is played with a period of two cycles. In that test the lane is given away and then taken back, and the wait states are held for several cycles. This separates correct phase lengths from lengths that are off by one period or one cycle, and shows whether the direction flag changes on the right edge. Further patterns use the far end's responses to tell the three ways a release can end apart: a correct answer, a silent far end that runs into the timeout, and an early LP-11 that aborts. A broken request with LP-01, a settle wait cut short by LP-11, and `ta_req` pulsed on a listener each show that a non-owner never drives unless the full order arrives. A period of zero shows the one-cycle minimum.

// File: rtl/lta_pkg.sv
package lta_pkg;

  typedef enum logic [3:0] {
    ST_OWN_IDLE,
    ST_TX_10A,
    ST_TX_00A,
    ST_TX_10B,
    ST_TX_BRIDGE,
    ST_WAIT_00,
    ST_WAIT_10,
    ST_LISTEN,
    ST_RQ_10A,
    ST_RQ_00A,
    ST_RQ_10B,
    ST_RX_SURE,
    ST_RX_GET,
    ST_RX_10
  } ta_state_e;

  localparam logic [1:0] LN_11 = 2'b11;
  localparam logic [1:0] LN_10 = 2'b10;
  localparam logic [1:0] LN_01 = 2'b01;
  localparam logic [1:0] LN_00 = 2'b00;

endpackage

// File: rtl/lta_phase_timer.sv
module lta_phase_timer #(
  parameter int CNT_W  = 8,
  parameter int MULT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CNT_W-1:0]  lpx,
  input  logic [MULT_W-1:0] mult,
  output logic              done
);
  localparam int LEN_W = CNT_W + MULT_W;

  logic [CNT_W-1:0] eff_lpx;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] cnt;

  // a zero period is taken as one cycle
  assign eff_lpx = (lpx == '0) ? CNT_W'(1) : lpx;
  assign len     = LEN_W'(mult) * LEN_W'(eff_lpx);
  assign done    = (cnt == len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (!done)  cnt <= cnt + LEN_W'(1);
  end
endmodule

// File: rtl/lta_line_drive.sv
module lta_line_drive
  import lta_pkg::*;
#(
  parameter bit INIT_OWNER = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ta_state_e  nxt,
  output logic [1:0] line_out,
  output logic       line_oe,
  output logic       own_lane
);
  logic [1:0] out_d;
  logic       oe_d;
  logic       own_d;

  always_comb begin
    out_d = LN_11;
    oe_d  = 1'b0;
    own_d = 1'b0;
    case (nxt)
      ST_OWN_IDLE:  begin out_d = LN_11; oe_d = 1'b1; own_d = 1'b1; end
      ST_TX_10A,
      ST_TX_10B:    begin out_d = LN_10; oe_d = 1'b1; own_d = 1'b1; end
      ST_TX_00A,
      ST_TX_BRIDGE: begin out_d = LN_00; oe_d = 1'b1; own_d = 1'b1; end
      ST_RX_GET:    begin out_d = LN_00; oe_d = 1'b1; own_d = 1'b0; end
      ST_RX_10:     begin out_d = LN_10; oe_d = 1'b1; own_d = 1'b0; end
      default:      begin out_d = LN_11; oe_d = 1'b0; own_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_out <= LN_11;
      line_oe  <= INIT_OWNER;
      own_lane <= INIT_OWNER;
    end else begin
      line_out <= out_d;
      line_oe  <= oe_d;
      own_lane <= own_d;
    end
  end
endmodule

// File: rtl/lp_lane_turnaround.sv
module lp_lane_turnaround
  import lta_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter bit INIT_OWNER = 1'b1,
  parameter int SURE_MULT  = 1,
  parameter int GO_MULT    = 4,
  parameter int GET_MULT   = 5,
  parameter int WAIT_MULT  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lpx_cycles,
  input  logic             ta_req,
  input  logic [1:0]       line_in,
  output logic [1:0]       line_out,
  output logic             line_oe,
  output logic             own_lane
);
  localparam int MULT_W = 4;
  localparam ta_state_e RST_ST = INIT_OWNER ? ST_OWN_IDLE : ST_LISTEN;

  ta_state_e         st, nxt;
  logic [MULT_W-1:0] mult;
  logic              done;

  always_comb begin
    nxt  = st;
    mult = MULT_W'(1);
    case (st)
      ST_OWN_IDLE:  if (ta_req) nxt = ST_TX_10A;
      ST_TX_10A:    if (done) nxt = ST_TX_00A;
      ST_TX_00A:    if (done) nxt = ST_TX_10B;
      ST_TX_10B:    if (done) nxt = ST_TX_BRIDGE;
      ST_TX_BRIDGE: begin
        mult = MULT_W'(GO_MULT);
        if (done) nxt = ST_WAIT_00;
      end
      ST_WAIT_00: begin
        mult = MULT_W'(WAIT_MULT);
        if (line_in == LN_10)                    nxt = ST_WAIT_10;
        else if (line_in != LN_00 || done)       nxt = ST_OWN_IDLE;
      end
      ST_WAIT_10: begin
        mult = MULT_W'(WAIT_MULT);
        if (line_in == LN_11)                    nxt = ST_LISTEN;
        else if (line_in != LN_10 || done)       nxt = ST_OWN_IDLE;
      end
      ST_LISTEN:    if (line_in == LN_10) nxt = ST_RQ_10A;
      ST_RQ_10A: begin
        if (line_in == LN_00)      nxt = ST_RQ_00A;
        else if (line_in != LN_10) nxt = ST_LISTEN;
      end
      ST_RQ_00A: begin
        if (line_in == LN_10)      nxt = ST_RQ_10B;
        else if (line_in != LN_00) nxt = ST_LISTEN;
      end
      ST_RQ_10B: begin
        if (line_in == LN_00)      nxt = ST_RX_SURE;
        else if (line_in != LN_10) nxt = ST_LISTEN;
      end
      ST_RX_SURE: begin
        mult = MULT_W'(SURE_MULT);
        if (line_in != LN_00) nxt = ST_LISTEN;
        else if (done)        nxt = ST_RX_GET;
      end
      ST_RX_GET: begin
        mult = MULT_W'(GET_MULT);
        if (done) nxt = ST_RX_10;
      end
      ST_RX_10:     if (done) nxt = ST_OWN_IDLE;
      default:      nxt = RST_ST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= RST_ST;
    else        st <= nxt;
  end

  lta_phase_timer #(
    .CNT_W  (CNT_W),
    .MULT_W (MULT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (nxt != st),
    .lpx   (lpx_cycles),
    .mult  (mult),
    .done  (done)
  );

  lta_line_drive #(
    .INIT_OWNER (INIT_OWNER)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .nxt      (nxt),
    .line_out (line_out),
    .line_oe  (line_oe),
    .own_lane (own_lane)
  );
endmodule

// File: rtl/lta_checker.sv
module lta_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ta_req,
  input logic [1:0] line_out,
  input logic       line_oe,
  input logic       own_lane
);
  // R3: releasing happens only out of the bridge state
  a_r3_bridge_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> ($past(line_out) == 2'b00) && $past(own_lane));

  // R3: an undriven lane reads stop and is never owned
  a_r3_float_is_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> (line_out == 2'b11) && !own_lane);

  // R2: owner leaves stop only into LP-10 and only on request
  a_r2_start_order: assert property (@(posedge clk) disable iff (!rst_n)
    (own_lane && $past(own_lane) && $past(line_out) == 2'b11 && line_out != 2'b11)
      |-> (line_out == 2'b10) && $past(ta_req));

  // R9: taking side starts driving with the bridge state
  a_r9_get_bridge: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(line_oe) && !own_lane) |-> line_out == 2'b00);

  // R10: ownership after driving follows an LP-10 period and lands in stop
  a_r10_take_order: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(own_lane) && $past(line_oe)) |-> ($past(line_out) == 2'b10) && line_out == 2'b11);
endmodule

bind lp_lane_turnaround lta_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ta_req   (ta_req),
  .line_out (line_out),
  .line_oe  (line_oe),
  .own_lane (own_lane)
);

// File: tb/lp_lane_turnaround_tb_top.sv
module lp_lane_turnaround_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lpx_cycles = 8'd2;
  logic       ta_req = 1'b0;
  logic [1:0] line_in = 2'b11;
  logic [1:0] line_out;
  logic       line_oe;
  logic       own_lane;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  lp_lane_turnaround dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lpx_cycles (lpx_cycles),
    .ta_req     (ta_req),
    .line_in    (line_in),
    .line_out   (line_out),
    .line_oe    (line_oe),
    .own_lane   (own_lane)
  );

  // {ta_req, line_in[1:0], exp line_out[1:0], exp oe, exp own}, period = 2 cycles
  localparam logic [6:0] VEC [39] = '{
    7'b0_11_11_1_1, // 0  idle owner
    7'b1_11_10_1_1, // 1  request -> LP-10
    7'b0_10_10_1_1,
    7'b0_10_00_1_1, // 3  LP-00
    7'b0_00_00_1_1,
    7'b0_00_10_1_1, // 5  LP-10
    7'b0_10_10_1_1,
    7'b0_00_00_1_1, // 7  bridge, 8 cycles
    7'b0_00_00_1_1,
    7'b0_00_00_1_1,
    7'b0_00_00_1_1,
    7'b0_00_00_1_1,
    7'b0_00_00_1_1,
    7'b0_00_00_1_1,
    7'b0_00_00_1_1,
    7'b0_00_11_0_0, // 15 released
    7'b0_00_11_0_0,
    7'b0_00_11_0_0,
    7'b0_10_11_0_0,
    7'b0_10_11_0_0,
    7'b0_11_11_0_0, // 20 listener
    7'b0_10_11_0_0, // 21 request from far end
    7'b0_00_11_0_0,
    7'b0_10_11_0_0,
    7'b0_00_11_0_0, // 24 settle wait
    7'b0_00_11_0_0,
    7'b0_00_00_1_0, // 26 get bridge, 10 cycles
    7'b0_00_00_1_0,
    7'b0_00_00_1_0,
    7'b0_00_00_1_0,
    7'b0_00_00_1_0,
    7'b0_00_00_1_0,
    7'b0_00_00_1_0,
    7'b0_00_00_1_0,
    7'b0_00_00_1_0,
    7'b0_00_00_1_0,
    7'b0_00_10_1_0, // 36 LP-10
    7'b0_00_10_1_0,
    7'b0_00_11_1_1  // 38 owner again
  };

  function automatic string tag_of(int i);
    if (i <= 6)       return "R2";
    else if (i <= 15) return "R3";
    else if (i <= 20) return "R4";
    else if (i <= 25) return "R7 R8";
    else if (i <= 35) return "R9";
    else              return "R10";
  endfunction

  task automatic chk(string tag, logic [1:0] e_out, logic e_oe, logic e_own);
    n_vec++;
    if (line_out !== e_out || line_oe !== e_oe || own_lane !== e_own) begin
      n_bad++;
      $display("FAIL %s: out=%b oe=%b own=%b expected out=%b oe=%b own=%b",
               tag, line_out, line_oe, own_lane, e_out, e_oe, e_own);
    end
  endtask

  // called at a negedge; applies inputs and returns at the next negedge
  task automatic step(logic req, logic [1:0] lin);
    ta_req  = req;
    line_in = lin;
    @(negedge clk);
  endtask

  task automatic release_to_wait();  // period 1: 8 edges to the wait state
    step(1'b1, 2'b11);
    for (int k = 0; k < 7; k++) step(1'b0, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 2'b11, 1'b1, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 2'b11, 1'b1, 1'b1);

    for (int i = 0; i < 39; i++) begin
      step(VEC[i][6], VEC[i][5:4]);
      chk(tag_of(i), VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end

    // R6: silent far end, period 1
    lpx_cycles = 8'd1;
    release_to_wait();
    chk("R3", 2'b11, 1'b0, 1'b0);
    for (int k = 0; k < 7; k++) step(1'b0, 2'b00);
    chk("R6", 2'b11, 1'b0, 1'b0);
    step(1'b0, 2'b00);
    chk("R6", 2'b11, 1'b1, 1'b1);

    // R5: early LP-11 while waiting for bridge
    release_to_wait();
    step(1'b0, 2'b11);
    chk("R5", 2'b11, 1'b1, 1'b1);

    // R4: proper answer, then R7 abort with LP-01
    release_to_wait();
    step(1'b0, 2'b00);
    step(1'b0, 2'b10);
    step(1'b0, 2'b11);
    chk("R4", 2'b11, 1'b0, 1'b0);
    step(1'b0, 2'b10);
    step(1'b0, 2'b01);
    for (int k = 0; k < 12; k++) step(1'b0, 2'b00);
    chk("R7", 2'b11, 1'b0, 1'b0);

    // R11: request ignored while listener
    step(1'b1, 2'b11);
    step(1'b0, 2'b11);
    chk("R11", 2'b11, 1'b0, 1'b0);

    // R8: settle wait broken by LP-11
    step(1'b0, 2'b10);
    step(1'b0, 2'b00);
    step(1'b0, 2'b10);
    step(1'b0, 2'b00);
    step(1'b0, 2'b11);
    for (int k = 0; k < 8; k++) step(1'b0, 2'b00);
    chk("R8", 2'b11, 1'b0, 1'b0);

    // R12: zero period acts as one cycle on the taking side
    lpx_cycles = 8'd0;
    step(1'b0, 2'b10);
    step(1'b0, 2'b00);
    step(1'b0, 2'b10);
    step(1'b0, 2'b00);
    step(1'b0, 2'b00);
    chk("R12", 2'b00, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b0, 2'b00);
    chk("R9", 2'b00, 1'b1, 1'b0);
    step(1'b0, 2'b00);
    chk("R10", 2'b10, 1'b1, 1'b0);
    step(1'b0, 2'b00);
    chk("R10", 2'b11, 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule